// File: doc/BRIEF.md
# Electronic Shutter Pulse Scheduler

This block decides when a sensor's substrate shutter pulse fires, so that exposure can be shortened electronically while the frame period stays fixed. The timing sequencer supplies three signals. A frame-start strobe marks line 0 of a frame. A line-start strobe marks each following line. A retrace level is high while horizontal clocking is stopped. The block counts lines. It places at most one pulse per frame inside the retrace of a chosen line, and that pulse clears the photodiodes. Integration then runs from the end of this pulse to the next readout transfer.

Exposure is programmed as a number of lines N. The pulse goes into the retrace of line `LINES - N`, so a larger N gives a longer exposure. The exposure value and the shutter enable are captured only at frame start. A new setting therefore always takes effect as a whole, on a frame boundary. With the shutter disabled, no pulse is emitted and integration spans the whole frame.

The pulse never overlaps horizontal readout. It begins a programmable number of clocks after retrace is first seen and lasts a programmable number of clocks. The block measures the length of the most recent retrace. If the pulse would not fit in that length, the pulse is dropped and a sticky error is raised. If retrace ends early while the pulse is pending or running, the pulse is cut off and the error is raised as well. Generating the high-voltage pulse itself is outside this block.

Top module: `shutter_scheduler`

## Requirements
- R1: After synchronous reset, `shutter_pulse` and `shutter_err` are both 0.
- R2: The pulse is high only while retrace is high. It rises on the GAP_CYC-th clock edge after the edge that first samples `retrace` high.
- R3: An undisturbed pulse stays high for exactly PULSE_CYC clock cycles.
- R4: Lines are numbered from 0, which starts at `frame_start`, and each `line_start` adds one. For exposure N, the pulse is placed in the retrace of line LINES − N.
- R5: An exposure of 0 is treated as 1, and an exposure above LINES − 1 is treated as LINES − 1.
- R6: At most one pulse starts between two consecutive frame starts.
- R7: Exposure and enable are sampled only on the `frame_start` cycle. Changes made later in the frame do not affect that frame's pulse.
- R8: When the enable sampled at frame start is 0, no pulse occurs in that frame.
- R9: If the most recently completed retrace lasted fewer than GAP_CYC + PULSE_CYC cycles, the target line's pulse is suppressed and `shutter_err` is set.
- R10: If retrace falls while the pulse is pending or high, the pulse drops on that edge and `shutter_err` is set.
- R11: Once `shutter_err` is set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe, start of line 0 |
| line_start | input | 1 | One-cycle strobe, start of each further line |
| retrace | input | 1 | High while horizontal clocking is stopped |
| shutter_en | input | 1 | Shutter enable, sampled at frame start |
| exposure_lines | input | EXP_W | Exposure in lines, sampled at frame start |
| shutter_pulse | output | 1 | Registered shutter pulse request |
| shutter_err | output | 1 | Sticky error for a suppressed or truncated pulse |

## Verification
The bench drives its inputs 1 ns after a rising edge and samples at the falling edge. It counts how many falling-edge samples retrace has been high. The edge that first sees retrace is preceded by one such sample. The registered pulse therefore appears at count GAP_CYC + 2, and the bench checks it there. The bench then expects PULSE_CYC high samples, or fewer after an early retrace fall. The line index, pulse count and width are collected over a whole frame and compared after the frame ends. The error flag is read only after the frame finishes, because it is due on the target line's first retrace edge or on the truncating edge.

// File: rtl/shutter_pkg.sv
package shutter_pkg;
  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_WAIT = 2'd1,
    SH_FIRE = 2'd2
  } sh_state_e;
endpackage

// File: rtl/shutter_line_tracker.sv
module shutter_line_tracker #(
  parameter int LINES  = 525,
  parameter int EXP_W  = 10,
  parameter int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              shutter_en,
  input  logic [EXP_W-1:0]  exposure_lines,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] tgt_q,
  output logic              en_q
);
  localparam logic [EXP_W-1:0]  MAX_EXP  = EXP_W'(LINES - 1);
  localparam logic [LINE_W-1:0] LAST_LN  = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] LINES_LW = LINE_W'(LINES);

  logic [EXP_W-1:0]  exp_clamped;
  logic [LINE_W-1:0] tgt_next;

  always_comb begin
    if (exposure_lines == '0)
      exp_clamped = EXP_W'(1);
    else if (exposure_lines > MAX_EXP)
      exp_clamped = MAX_EXP;
    else
      exp_clamped = exposure_lines;
    tgt_next = LINES_LW - LINE_W'(exp_clamped);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      tgt_q  <= LAST_LN;
      en_q   <= 1'b0;
    end else if (frame_start) begin
      line_q <= '0;
      tgt_q  <= tgt_next;
      en_q   <= shutter_en;
    end else if (line_start && line_q != LAST_LN) begin
      line_q <= line_q + LINE_W'(1);
    end
  end

  // R5: the captured target line stays within 1 .. LINES-1
  p_target_range_r5: assert property (@(posedge clk) disable iff (rst)
    (tgt_q >= LINE_W'(1)) && (tgt_q <= LAST_LN));
endmodule

// File: rtl/shutter_window_meter.sv
module shutter_window_meter #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retrace,
  output logic             rise,
  output logic [LEN_W-1:0] last_len
);
  logic             rt_q;
  logic [LEN_W-1:0] len_cnt;

  assign rise = retrace & ~rt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_q     <= 1'b0;
      len_cnt  <= '0;
      last_len <= '0;
    end else begin
      rt_q <= retrace;
      if (rise)
        len_cnt <= LEN_W'(1);
      else if (retrace && len_cnt != '1)
        len_cnt <= len_cnt + LEN_W'(1);
      if (!retrace && rt_q)
        last_len <= len_cnt;
    end
  end
endmodule

// File: rtl/shutter_pulse_fsm.sv
module shutter_pulse_fsm
  import shutter_pkg::*;
#(
  parameter int GAP_CYC   = 250,
  parameter int PULSE_CYC = 1250,
  parameter int LINE_W    = 10,
  parameter int LEN_W     = 11,
  parameter int CNT_W     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              en_q,
  input  logic [LINE_W-1:0] line_q,
  input  logic [LINE_W-1:0] tgt_q,
  input  logic              retrace,
  input  logic              rise,
  input  logic [LEN_W-1:0]  last_len,
  output logic              pulse_q,
  output logic              err_q
);
  localparam logic [LEN_W-1:0] NEED_LEN = LEN_W'(GAP_CYC + PULSE_CYC);
  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] FIRE_END = CNT_W'(PULSE_CYC - 1);

  sh_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             fs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SH_IDLE;
      cnt     <= '0;
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
      armed   <= 1'b0;
      fs_d    <= 1'b0;
    end else begin
      fs_d <= frame_start;
      if (frame_start) begin
        state   <= SH_IDLE;
        pulse_q <= 1'b0;
        armed   <= 1'b0;
      end else begin
        if (fs_d) armed <= en_q;
        unique case (state)
          SH_IDLE: begin
            if (rise && armed && line_q == tgt_q) begin
              armed <= 1'b0;
              if (last_len >= NEED_LEN) begin
                state <= SH_WAIT;
                cnt   <= '0;
              end else begin
                err_q <= 1'b1;
              end
            end
          end
          SH_WAIT: begin
            if (!retrace) begin
              state <= SH_IDLE;
              err_q <= 1'b1;
            end else if (cnt == GAP_END) begin
              state   <= SH_FIRE;
              cnt     <= '0;
              pulse_q <= 1'b1;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          SH_FIRE: begin
            if (!retrace) begin
              state   <= SH_IDLE;
              pulse_q <= 1'b0;
              err_q   <= 1'b1;
            end else if (cnt == FIRE_END) begin
              state   <= SH_IDLE;
              pulse_q <= 1'b0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: state <= SH_IDLE;
        endcase
      end
    end
  end

  // Support counter for the once-per-frame property
  logic       pulse_prev;
  logic [1:0] fires_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_prev <= 1'b0;
      fires_seen <= '0;
    end else begin
      pulse_prev <= pulse_q;
      if (frame_start)
        fires_seen <= '0;
      else if (pulse_q && !pulse_prev && fires_seen != 2'd3)
        fires_seen <= fires_seen + 2'd1;
    end
  end

  // R2: a high pulse was set or kept only while retrace was sampled high
  p_pulse_in_retrace_r2: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $past(retrace));

  // R6: no second pulse start inside one frame
  p_one_per_frame_r6: assert property (@(posedge clk) disable iff (rst)
    fires_seen <= 2'd1);

  // R11: the error flag never clears without reset
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/shutter_scheduler.sv
module shutter_scheduler #(
  parameter int LINES     = 525,
  parameter int EXP_W     = 10,
  parameter int GAP_CYC   = 250,
  parameter int PULSE_CYC = 1250
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             line_start,
  input  logic             retrace,
  input  logic             shutter_en,
  input  logic [EXP_W-1:0] exposure_lines,
  output logic             shutter_pulse,
  output logic             shutter_err
);
  localparam int LINE_W = $clog2(LINES);
  localparam int LEN_W  = $clog2(GAP_CYC + PULSE_CYC + 1);
  localparam int CNT_MX = (GAP_CYC > PULSE_CYC) ? GAP_CYC : PULSE_CYC;
  localparam int CNT_W  = $clog2(CNT_MX + 1);

  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] tgt_q;
  logic              en_q;
  logic              rise;
  logic [LEN_W-1:0]  last_len;

  shutter_line_tracker #(
    .LINES (LINES),
    .EXP_W (EXP_W),
    .LINE_W(LINE_W)
  ) u_lines (
    .clk           (clk),
    .rst           (rst),
    .frame_start   (frame_start),
    .line_start    (line_start),
    .shutter_en    (shutter_en),
    .exposure_lines(exposure_lines),
    .line_q        (line_q),
    .tgt_q         (tgt_q),
    .en_q          (en_q)
  );

  shutter_window_meter #(
    .LEN_W(LEN_W)
  ) u_window (
    .clk     (clk),
    .rst     (rst),
    .retrace (retrace),
    .rise    (rise),
    .last_len(last_len)
  );

  shutter_pulse_fsm #(
    .GAP_CYC  (GAP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .LINE_W   (LINE_W),
    .LEN_W    (LEN_W),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .en_q       (en_q),
    .line_q     (line_q),
    .tgt_q      (tgt_q),
    .retrace    (retrace),
    .rise       (rise),
    .last_len   (last_len),
    .pulse_q    (shutter_pulse),
    .err_q      (shutter_err)
  );

  // R8: a pulse is only ever seen while the frame's captured enable is set
  p_pulse_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
    shutter_pulse |-> en_q);
endmodule

// File: tb/tb_shutter_scheduler.sv
`timescale 1ns/1ps
module tb_shutter_scheduler;
  localparam int LINES = 20;
  localparam int EXP_W = 10;
  localparam int GAP   = 3;
  localparam int PW    = 6;
  localparam int ACT   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic line_start = 1'b0;
  logic retrace = 1'b0;
  logic shutter_en = 1'b0;
  logic [EXP_W-1:0] exposure_lines = '0;
  logic shutter_pulse;
  logic shutter_err;

  always #2 clk = ~clk;

  shutter_scheduler #(
    .LINES(LINES), .EXP_W(EXP_W), .GAP_CYC(GAP), .PULSE_CYC(PW)
  ) dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .retrace(retrace), .shutter_en(shutter_en), .exposure_lines(exposure_lines),
    .shutter_pulse(shutter_pulse), .shutter_err(shutter_err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int cur_line = 0;
  int rt_default = 12;
  int sp_line = -1;
  int sp_len = 0;
  int mid_line = -1;
  int mid_exp = 0;
  bit mid_en = 1'b0;

  int rt_seen = 0;
  int n_pulses = 0;
  int p_line = -1;
  int p_width = 0;
  int p_gap = 0;
  int overlap = 0;
  bit pulse_prev = 1'b0;

  always @(negedge clk) begin
    if (retrace) rt_seen = rt_seen + 1; else rt_seen = 0;
    if (shutter_pulse) begin
      if (!pulse_prev) begin
        n_pulses = n_pulses + 1;
        p_line = cur_line;
        p_gap = rt_seen;
      end
      p_width = p_width + 1;
      if (!retrace) overlap = overlap + 1;
    end
    pulse_prev = shutter_pulse;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic run_frame();
    n_pulses = 0; p_line = -1; p_width = 0; p_gap = 0; overlap = 0;
    for (int l = 0; l < LINES; l++) begin
      tick();
      cur_line = l;
      if (l == 0) frame_start = 1'b1; else line_start = 1'b1;
      if (l == mid_line) begin
        exposure_lines = EXP_W'(mid_exp);
        shutter_en = mid_en;
      end
      tick();
      frame_start = 1'b0;
      line_start = 1'b0;
      repeat (ACT - 1) tick();
      retrace = 1'b1;
      repeat ((l == sp_line) ? sp_len : rt_default) tick();
      retrace = 1'b0;
    end
    repeat (3) tick();
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(shutter_pulse == 1'b0, "R1 pulse after reset", int'(shutter_pulse), 0);
    chk(shutter_err == 1'b0, "R1 err after reset", int'(shutter_err), 0);
  endtask

  task automatic t_basic();
    shutter_en = 1'b1; exposure_lines = 10'd5;
    run_frame();
    chk(n_pulses == 1, "R6 one pulse", n_pulses, 1);
    chk(p_line == LINES - 5, "R4 line for N=5", p_line, LINES - 5);
    chk(p_width == PW, "R3 width", p_width, PW);
    chk(p_gap == GAP + 2, "R2 gap", p_gap, GAP + 2);
    chk(overlap == 0, "R2 overlap", overlap, 0);
    chk(shutter_err == 1'b0, "R9 no err", int'(shutter_err), 0);
  endtask

  task automatic one_exp(input int n, input int exp_line, input string req);
    shutter_en = 1'b1; exposure_lines = EXP_W'(n);
    run_frame();
    chk(n_pulses == 1 && p_line == exp_line, req, p_line, exp_line);
  endtask

  task automatic t_exposures();
    one_exp(1, LINES - 1, "R4 N=1");
    one_exp(LINES - 1, 1, "R4 N=max");
    one_exp(10, LINES - 10, "R4 N=10");
    one_exp(0, LINES - 1, "R5 clamp low");
    one_exp(600, 1, "R5 clamp high");
  endtask

  task automatic t_disable();
    shutter_en = 1'b0; exposure_lines = 10'd5;
    run_frame();
    chk(n_pulses == 0, "R8 disabled", n_pulses, 0);
  endtask

  task automatic t_latch();
    shutter_en = 1'b1; exposure_lines = 10'd5;
    mid_line = 3; mid_exp = 12; mid_en = 1'b1;
    run_frame();
    chk(p_line == LINES - 5, "R7 mid-frame exposure ignored", p_line, LINES - 5);
    mid_line = -1;
    run_frame();
    chk(p_line == LINES - 12, "R7 applied next frame", p_line, LINES - 12);
    shutter_en = 1'b0;
    mid_line = 3; mid_exp = 12; mid_en = 1'b1;
    run_frame();
    chk(n_pulses == 0, "R7 mid-frame enable ignored", n_pulses, 0);
    mid_line = -1;
  endtask

  task automatic t_short_window();
    shutter_en = 1'b1; exposure_lines = 10'd5;
    rt_default = GAP + PW - 2;
    run_frame();
    chk(n_pulses == 0, "R9 suppressed", n_pulses, 0);
    chk(shutter_err == 1'b1, "R9 err set", int'(shutter_err), 1);
    rt_default = 12;
    run_frame();
    chk(n_pulses == 1, "R11 pulses continue", n_pulses, 1);
    chk(shutter_err == 1'b1, "R11 err sticky", int'(shutter_err), 1);
    do_reset();
    #1;
    chk(shutter_err == 1'b0, "R1 err cleared by reset", int'(shutter_err), 0);
  endtask

  task automatic t_truncate();
    shutter_en = 1'b1; exposure_lines = 10'd5;
    sp_line = LINES - 5; sp_len = GAP + 3;
    run_frame();
    chk(n_pulses == 1, "R10 pulse started", n_pulses, 1);
    chk(p_width == 3, "R10 truncated width", p_width, 3);
    chk(shutter_err == 1'b1, "R10 err set", int'(shutter_err), 1);
    sp_line = -1;
    do_reset();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_exposures();
    t_disable();
    t_latch();
    t_short_window();
    t_truncate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule